// File: doc/BRIEF.md
# Processor Operating Mode Decoder

This block turns a handful of architectural state bits into one registered mode word that the rest of a processor core reads to learn how it is currently executing. From the long-mode-active bit, the protection-enable and paging bits of the primary control register, the code-segment long, default-size and privilege fields, the stack-segment default-size flag and the virtual-8086 flag, it derives a mode, a submode, the current privilege level, and the default and alternate operand sizes, address sizes and the stack size.

The word is not tracked continuously. It is recaptured only when a write lands on one of the source-register addresses, or when a write lands on the mode word's own address, which acts as a refresh command: the block has no data port, so any written value is simply discarded. The architectural flag inputs are expected to show the post-write value in the same cycle as the write strobe, and the new word is visible from the cycle after it. Writes to any other address leave the word untouched.

Top module: `mode_decoder`

## Requirements
- R1: While reset (rstN low) is applied, and after release until the first capture, modeWord is all zeros.
- R2: Word layout from bit 0 upward is: mode (1 bit), submode (3 bits), privilege (2 bits), paging, protection, default operand size (2), alternate operand size (2), default address size (2), alternate address size (2), stack size (2). With lmaBit set, mode is 1 and submode is 4 (64-bit) when csLong is set, else 3 (compatibility).
- R3: With lmaBit clear, mode is 0 and submode is 0 (real) when peBit is 0, else 2 (virtual-8086) when vmFlag is set, else 1 (protected).
- R4: The privilege field holds csDpl, the paging field holds pgBit and the protection field holds peBit, as sampled at the capture.
- R5: Operand sizes use log2-of-bytes codes: default 2 and alternate 1 when the submode is 64-bit or csDefSize is set; otherwise default 1 and alternate 2.
- R6: Address sizes are default 3 and alternate 2 in 64-bit submode; otherwise default 2 and alternate 1 when csDefSize is set; otherwise default 1 and alternate 2.
- R7: Stack size is 3 in 64-bit submode; otherwise 2 when ssDefSize is set, else 1.
- R8: A write (wrEn high) to any source address 0 to 4 captures the decode of the current inputs at that clock edge; the word changes on the following cycle.
- R9: A write to the mode word address 5 captures the decode of the current inputs in the same way; nothing else about the write has an effect.
- R10: With wrEn low, or with a write to any address from 6 to 15, modeWord keeps its value whatever the flag inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 4 | Address of the register being written |
| lmaBit | input | 1 | Long mode active |
| peBit | input | 1 | Protection enable |
| pgBit | input | 1 | Paging enable |
| csLong | input | 1 | Code segment long flag |
| csDefSize | input | 1 | Code segment default-size flag |
| csDpl | input | 2 | Code segment privilege level |
| ssDefSize | input | 1 | Stack segment default-size flag |
| vmFlag | input | 1 | Virtual-8086 flag |
| modeWord | output | 18 | Packed mode word |

## Verification
The properties assume that the flag inputs already carry the value being written in the very cycle the write strobe is high, so that a capture compares against what was on the pins at that edge. The stimulus honours this by changing the flags and raising the strobe together on the falling edge and only reading the word one cycle later. Hold checks deliberately move every flag while writing to foreign addresses, so a spurious capture would show at the output.

// File: rtl/mode_pkg.sv
package mode_pkg;
  localparam int CPL_W  = 2;
  localparam int SIZE_W = 2;
  localparam int SUB_W  = 3;

  typedef enum logic [SUB_W-1:0] {
    SUB_REAL   = 3'd0,
    SUB_PROT   = 3'd1,
    SUB_V86    = 3'd2,
    SUB_COMPAT = 3'd3,
    SUB_LONG64 = 3'd4
  } submode_e;

  // Bit 0 is the mode bit; fields rise in significance toward stackSz.
  typedef struct packed {
    logic [SIZE_W-1:0] stackSz;
    logic [SIZE_W-1:0] altAddr;
    logic [SIZE_W-1:0] defAddr;
    logic [SIZE_W-1:0] altOp;
    logic [SIZE_W-1:0] defOp;
    logic              prot;
    logic              paging;
    logic [CPL_W-1:0]  cpl;
    submode_e          submode;
    logic              isLong;
  } mode_word_t;

  localparam int WORD_W = $bits(mode_word_t);

  typedef struct packed {
    logic load;
  } ctrl_strobe_t;
endpackage

// File: rtl/mode_ctrl.sv
module mode_ctrl
  import mode_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int NUM_SRC   = 5,
  parameter int MODE_ADDR = 5
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  output ctrl_strobe_t      strobe
);
  logic [NUM_SRC-1:0] srcHit;
  logic               selfHit;

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
    assign srcHit[k] = wrEn && (wrAddr == ADDR_W'(k));
  end

  assign selfHit = wrEn && (wrAddr == ADDR_W'(MODE_ADDR));

  always_comb begin
    strobe      = '0;
    strobe.load = (|srcHit) || selfHit;
  end
endmodule

// File: rtl/mode_datapath.sv
module mode_datapath
  import mode_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  ctrl_strobe_t     strobe,
  input  logic             lmaBit,
  input  logic             peBit,
  input  logic             pgBit,
  input  logic             csLong,
  input  logic             csDefSize,
  input  logic [CPL_W-1:0] csDpl,
  input  logic             ssDefSize,
  input  logic             vmFlag,
  output mode_word_t       wordQ
);
  mode_word_t nextWord;
  logic       is64;

  always_comb begin
    nextWord        = '0;
    nextWord.isLong = lmaBit;
    if (lmaBit) begin
      nextWord.submode = csLong ? SUB_LONG64 : SUB_COMPAT;
    end else if (!peBit) begin
      nextWord.submode = SUB_REAL;
    end else begin
      nextWord.submode = vmFlag ? SUB_V86 : SUB_PROT;
    end
    is64            = (nextWord.submode == SUB_LONG64);
    nextWord.cpl    = csDpl;
    nextWord.paging = pgBit;
    nextWord.prot   = peBit;

    if (is64 || csDefSize) begin
      nextWord.defOp = SIZE_W'(2);
      nextWord.altOp = SIZE_W'(1);
    end else begin
      nextWord.defOp = SIZE_W'(1);
      nextWord.altOp = SIZE_W'(2);
    end

    if (is64) begin
      nextWord.defAddr = SIZE_W'(3);
      nextWord.altAddr = SIZE_W'(2);
    end else if (csDefSize) begin
      nextWord.defAddr = SIZE_W'(2);
      nextWord.altAddr = SIZE_W'(1);
    end else begin
      nextWord.defAddr = SIZE_W'(1);
      nextWord.altAddr = SIZE_W'(2);
    end

    if (is64) begin
      nextWord.stackSz = SIZE_W'(3);
    end else if (ssDefSize) begin
      nextWord.stackSz = SIZE_W'(2);
    end else begin
      nextWord.stackSz = SIZE_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wordQ <= '0;
    end else if (strobe.load) begin
      wordQ <= nextWord;
    end
  end
endmodule

// File: rtl/mode_decoder.sv
module mode_decoder
  import mode_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int NUM_SRC   = 5,
  parameter int MODE_ADDR = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic              lmaBit,
  input  logic              peBit,
  input  logic              pgBit,
  input  logic              csLong,
  input  logic              csDefSize,
  input  logic [CPL_W-1:0]  csDpl,
  input  logic              ssDefSize,
  input  logic              vmFlag,
  output logic [WORD_W-1:0] modeWord
);
  ctrl_strobe_t strobe;
  mode_word_t   wordQ;

  mode_ctrl #(
    .ADDR_W(ADDR_W), .NUM_SRC(NUM_SRC), .MODE_ADDR(MODE_ADDR)
  ) u_ctrl (
    .wrEn(wrEn), .wrAddr(wrAddr), .strobe(strobe)
  );

  mode_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .lmaBit(lmaBit), .peBit(peBit), .pgBit(pgBit),
    .csLong(csLong), .csDefSize(csDefSize), .csDpl(csDpl),
    .ssDefSize(ssDefSize), .vmFlag(vmFlag), .wordQ(wordQ)
  );

  assign modeWord = wordQ;
endmodule

// File: rtl/mode_decoder_chk.sv
module mode_decoder_chk
  import mode_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int NUM_SRC   = 5,
  parameter int MODE_ADDR = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic              lmaBit,
  input logic              peBit,
  input logic              pgBit,
  input logic              csLong,
  input logic              csDefSize,
  input logic [CPL_W-1:0]  csDpl,
  input logic              ssDefSize,
  input logic              vmFlag,
  input logic [WORD_W-1:0] modeWord
);
  mode_word_t w;
  logic       trig;
  logic       selfWr;

  assign w      = mode_word_t'(modeWord);
  assign selfWr = wrEn && (wrAddr == ADDR_W'(MODE_ADDR));
  assign trig   = selfWr || (wrEn && (wrAddr < ADDR_W'(NUM_SRC)));

  // R10: no capture, no change
  p_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !trig |=> $stable(modeWord));

  // R2: mode bit follows long-mode-active after a capture
  p_mode_r2: assert property (@(posedge clk) disable iff (!rstN)
    trig |=> (w.isLong == $past(lmaBit)));

  // R2: long mode only has the 64-bit and compatibility submodes
  p_long_sub_r2: assert property (@(posedge clk) disable iff (!rstN)
    w.isLong |-> (w.submode == SUB_LONG64 || w.submode == SUB_COMPAT));

  // R3: legacy mode only has real, protected and virtual-8086 submodes
  p_legacy_sub_r3: assert property (@(posedge clk) disable iff (!rstN)
    !w.isLong |-> (w.submode == SUB_REAL || w.submode == SUB_PROT || w.submode == SUB_V86));

  // R4: privilege and paging copied from the pins at the capture
  p_cpl_pg_r4: assert property (@(posedge clk) disable iff (!rstN)
    trig |=> (w.cpl == $past(csDpl) && w.paging == $past(pgBit)));

  // R5: once loaded, default and alternate operand sizes are 1 and 2 in some order
  p_op_pair_r5: assert property (@(posedge clk) disable iff (!rstN)
    (modeWord != '0) |-> (({1'b0, w.defOp} + {1'b0, w.altOp}) == 3'd3));

  // R7: 64-bit submode implies an 8-byte stack
  p_stack_r7: assert property (@(posedge clk) disable iff (!rstN)
    (w.submode == SUB_LONG64) |-> (w.stackSz == 2'd3));

  // R9: refresh write captures protection-enable
  p_refresh_r9: assert property (@(posedge clk) disable iff (!rstN)
    selfWr |=> (w.prot == $past(peBit)));
endmodule

bind mode_decoder mode_decoder_chk #(
  .ADDR_W(ADDR_W), .NUM_SRC(NUM_SRC), .MODE_ADDR(MODE_ADDR)
) u_chk (.*);

// File: tb/mode_decoder_tb.sv
module mode_decoder_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [3:0]  wrAddr = '0;
  logic        lmaBit = 1'b0, peBit = 1'b0, pgBit = 1'b0;
  logic        csLong = 1'b0, csDefSize = 1'b0, ssDefSize = 1'b0, vmFlag = 1'b0;
  logic [1:0]  csDpl = '0;
  logic [17:0] modeWord;

  int nChecks = 0;
  int nFails  = 0;

  always #10 clk = ~clk;

  mode_decoder u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .lmaBit(lmaBit), .peBit(peBit), .pgBit(pgBit),
    .csLong(csLong), .csDefSize(csDefSize), .csDpl(csDpl),
    .ssDefSize(ssDefSize), .vmFlag(vmFlag), .modeWord(modeWord)
  );

  task automatic check(input string tag, input logic [17:0] act, input logic [17:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [17:0] refWord(
      input logic lma, input logic pe, input logic pg, input logic cl,
      input logic cd, input logic [1:0] dpl, input logic sd, input logic vm);
    logic [2:0] sub;
    logic [1:0] dOp, aOp, dAd, aAd, stk;
    if (lma) sub = cl ? 3'd4 : 3'd3;
    else if (!pe) sub = 3'd0;
    else sub = vm ? 3'd2 : 3'd1;
    dOp = (sub == 3'd4 || cd) ? 2'd2 : 2'd1;
    aOp = 2'd3 - dOp;
    if (sub == 3'd4) begin dAd = 2'd3; aAd = 2'd2; end
    else if (cd) begin dAd = 2'd2; aAd = 2'd1; end
    else begin dAd = 2'd1; aAd = 2'd2; end
    stk = (sub == 3'd4) ? 2'd3 : (sd ? 2'd2 : 2'd1);
    return {stk, aAd, dAd, aOp, dOp, pe, pg, dpl, sub, lma};
  endfunction

  task automatic applyFlags(input int v);
    lmaBit    = v[0];
    peBit     = v[1];
    vmFlag    = v[2];
    csLong    = v[3];
    csDefSize = v[4];
    ssDefSize = v[5];
    pgBit     = v[1] ^ v[5];
    csDpl     = 2'((v + v / 8) % 4);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    logic [17:0] exp;
    logic [17:0] held;
    repeat (3) @(negedge clk);
    check("R1 in reset", modeWord, '0);
    rstN = 1'b1;
    applyFlags(63);
    @(negedge clk);
    check("R1 after release, no capture", modeWord, '0);

    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      applyFlags(i);
      wrEn   = 1'b1;
      wrAddr = 4'(i % 6);
      exp = refWord(lmaBit, peBit, pgBit, csLong, csDefSize, csDpl, ssDefSize, vmFlag);
      @(negedge clk);
      wrEn = 1'b0;
      if (exp[0]) check("R2 mode/submode", {14'd0, modeWord[3:0]}, {14'd0, exp[3:0]});
      else        check("R3 mode/submode", {14'd0, modeWord[3:0]}, {14'd0, exp[3:0]});
      check("R4 cpl/paging/prot", {14'd0, modeWord[7:4]}, {14'd0, exp[7:4]});
      check("R5 operand sizes", {14'd0, modeWord[11:8]}, {14'd0, exp[11:8]});
      check("R6 address sizes", {14'd0, modeWord[15:12]}, {14'd0, exp[15:12]});
      check("R7 stack size", {16'd0, modeWord[17:16]}, {16'd0, exp[17:16]});
      if (i % 6 == 5) check("R9 refresh write", modeWord, exp);
      else            check("R8 source write", modeWord, exp);
    end

    // R10: foreign addresses and idle cycles must not capture
    held = modeWord;
    for (int a = 6; a < 16; a++) begin
      @(negedge clk);
      applyFlags(a * 5);
      wrEn   = 1'b1;
      wrAddr = 4'(a);
      @(negedge clk);
      wrEn = 1'b0;
      check("R10 foreign address hold", modeWord, held);
    end
    @(negedge clk);
    applyFlags(22);
    repeat (2) @(negedge clk);
    check("R10 idle hold", modeWord, held);

    // R9: refresh picks up the flags that changed while idle
    exp = refWord(lmaBit, peBit, pgBit, csLong, csDefSize, csDpl, ssDefSize, vmFlag);
    wrEn   = 1'b1;
    wrAddr = 4'd5;
    @(negedge clk);
    wrEn = 1'b0;
    check("R9 refresh after idle", modeWord, exp);

    // R1: reset mid-run clears the word
    rstN = 1'b0;
    @(negedge clk);
    check("R1 reset mid-run", modeWord, '0);
    rstN = 1'b1;
    @(negedge clk);

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule